// File: doc/BRIEF.md
# Lane-Striped Vector Slide Datapath

This block moves bytes around within one beat of a vector register. The beat is spread across a parameterized number of 64-bit lanes. A beat holds `NR_LANES * 8` bytes, which is 32 bytes with the default of four lanes. The network is combinational, and an optional output register sits behind it.

Each beat is handled in one of two ways:

- **Slide.** All elements of a single width move up or down by a power-of-two number of element positions. Positions left empty are filled with zero bytes.
- **Reshuffle.** This is a slide by zero in which the source and destination element widths differ. The logical byte order of the vector is kept, and the bytes are laid out again in the lane layout of the destination width.

The two operations are never combined. A control set that asks for both, or a slide amount that is not a power of two, is flagged and produces an all-zero beat. Slides with a non-power-of-two amount must be split into power-of-two steps before they reach this block. Reshuffles are used when the element width of a register changes.

Top module: `sld_lane_slide`

## Requirements
- R1: Widths are encoded as 2-bit codes 0, 1, 2 and 3 for 8, 16, 32 and 64-bit elements. For a width of W bytes, element e sits in lane (e mod NR_LANES) at byte offset (e div NR_LANES)*W of that lane. Lane l occupies beat bits [64l+63 : 64l], and byte b of an element is stored at its offset plus b.
- R2: With `slide_amt` = 0 and equal source and destination widths, the beat passes through unchanged and `out_illegal` is 0.
- R3: With `slide_dn` = 1 and equal widths, a legal amount k sets output element e to input element e+k. The element is all zero when e+k is at or beyond the element count N = bytes-per-beat / W.
- R4: With `slide_dn` = 0 and equal widths, a legal amount k sets output element e to input element e−k. The element is all zero when e < k.
- R5: With `slide_amt` = 0 and differing widths, logical byte j = e*W+b is the same in input and output. It is read with the source-width layout and written with the destination-width layout. `out_illegal` is 0.
- R6: A nonzero `slide_amt` with differing widths sets `out_illegal` to 1 and drives an all-zero beat.
- R7: A nonzero `slide_amt` that is not a power of two sets `out_illegal` to 1 and drives an all-zero beat.
- R8: A legal slide amount at or above N elements, in either direction, yields an all-zero beat with `out_illegal` = 0.
- R9: With the output register enabled, the result of a beat sampled while `in_valid` is 1 appears one clock later, and `out_valid` equals `in_valid` of the previous cycle. While `in_valid` is 0, `out_beat` and `out_illegal` hold their values.
- R10: Synchronous active-low reset clears `out_valid`, `out_illegal` and `out_beat` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Beat and controls are valid this cycle |
| in_beat | input | NR_LANES*64 | Input beat, lane 0 in the low bits |
| src_ew | input | 2 | Source element width code (0..3 = 8..64 bits) |
| dst_ew | input | 2 | Destination element width code |
| slide_amt | input | $clog2(NR_LANES*8)+1 | Slide amount in elements; 0 selects pass or reshuffle |
| slide_dn | input | 1 | Direction: 1 slides down, 0 slides up |
| out_valid | output | 1 | Output beat is valid |
| out_beat | output | NR_LANES*64 | Permuted beat |
| out_illegal | output | 1 | Control combination was rejected |

## Verification
The network keeps no state apart from the output register. A wrong byte route, fill decision or legality decode therefore shows up at `out_beat` or `out_illegal` one clock after the beat that triggers it. A stale or corrupted output register shows up on the first idle cycle as a changed held value, or as an `out_valid` that does not follow `in_valid` delayed by one cycle. Because the bench compares every port on every clock, a single misrouted byte in any lane is reported in the cycle where it first appears.

// File: rtl/sld_pkg.sv
package sld_pkg;

   localparam int LANE_BYTES = 8;

   typedef enum logic [1:0] {
      EW_B8  = 2'd0,
      EW_B16 = 2'd1,
      EW_B32 = 2'd2,
      EW_B64 = 2'd3
   } ew_code_e;

   function automatic int ew_bytes(input logic [1:0] code);
      return 1 << code;
   endfunction

   // flat byte index of byte b of element e for width w bytes
   function automatic int byte_home(input int e, input int b, input int w, input int lanes);
      return (e % lanes) * LANE_BYTES + (e / lanes) * w + b;
   endfunction

endpackage

// File: rtl/sld_ctrl.sv
module sld_ctrl #(
   parameter int AMT_W = 6
) (
   input  logic [1:0]       src_ew,
   input  logic [1:0]       dst_ew,
   input  logic [AMT_W-1:0] amt,
   output logic             reject
);
   logic amt_nz;
   logic amt_multi;
   logic width_change;

   always_comb begin
      amt_nz       = |amt;
      amt_multi    = |(amt & (amt - 1'b1));
      width_change = (src_ew != dst_ew);
      reject       = amt_nz && (width_change || amt_multi);
   end
endmodule

// File: rtl/sld_xbar.sv
module sld_xbar #(
   parameter int NR_LANES = 4,
   parameter int AMT_W    = 6,
   localparam int NB      = NR_LANES * sld_pkg::LANE_BYTES
) (
   input  logic [NB*8-1:0]  in_beat,
   input  logic [1:0]       src_ew,
   input  logic [1:0]       dst_ew,
   input  logic [AMT_W-1:0] amt,
   input  logic             dn,
   input  logic             kill,
   output logic [NB*8-1:0]  out_beat
);
   import sld_pkg::*;

   for (genvar p = 0; p < NB; p++) begin : g_byte
      logic [7:0] pick;

      always_comb begin
         int wd;
         int ws;
         int slot_j;
         int js;
         int src;
         logic hit;
         wd     = ew_bytes(dst_ew);
         ws     = ew_bytes(src_ew);
         // logical byte held by this output position under the destination layout
         slot_j = (((p % LANE_BYTES) / wd) * NR_LANES + (p / LANE_BYTES)) * wd
                  + ((p % LANE_BYTES) % wd);
         if (dn) js = slot_j + int'(amt) * wd;
         else    js = slot_j - int'(amt) * wd;
         hit = !kill && (js >= 0) && (js < NB);
         if (hit) src = byte_home(js / ws, js % ws, ws, NR_LANES);
         else     src = 0;
         pick = hit ? in_beat[src*8 +: 8] : 8'h00;
      end

      assign out_beat[p*8 +: 8] = pick;
   end
endmodule

// File: rtl/sld_outreg.sv
module sld_outreg #(
   parameter int W       = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         d_valid,
   input  logic [W-1:0] d,
   output logic         q_valid,
   output logic [W-1:0] q
);
   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q_valid <= 1'b0;
            q       <= '0;
         end else begin
            q_valid <= d_valid;
            if (d_valid) q <= d;
         end
      end
   end else begin : g_wire
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q_valid    = d_valid;
      assign q          = d;
   end
endmodule

// File: rtl/sld_lane_slide.sv
module sld_lane_slide #(
   parameter int  NR_LANES = 4,
   parameter bit  REG_OUT  = 1'b1,
   localparam int NB       = NR_LANES * sld_pkg::LANE_BYTES,
   localparam int AMT_W    = $clog2(NB) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [NB*8-1:0]  in_beat,
   input  logic [1:0]       src_ew,
   input  logic [1:0]       dst_ew,
   input  logic [AMT_W-1:0] slide_amt,
   input  logic             slide_dn,
   output logic             out_valid,
   output logic [NB*8-1:0]  out_beat,
   output logic             out_illegal
);
   if (NR_LANES < 1) begin : g_bad_lanes
      $error("sld_lane_slide: NR_LANES must be at least 1");
   end

   logic            reject;
   logic [NB*8-1:0] net_beat;

   sld_ctrl #(.AMT_W(AMT_W)) u_ctrl (
      .src_ew (src_ew),
      .dst_ew (dst_ew),
      .amt    (slide_amt),
      .reject (reject)
   );

   sld_xbar #(.NR_LANES(NR_LANES), .AMT_W(AMT_W)) u_xbar (
      .in_beat  (in_beat),
      .src_ew   (src_ew),
      .dst_ew   (dst_ew),
      .amt      (slide_amt),
      .dn       (slide_dn),
      .kill     (reject),
      .out_beat (net_beat)
   );

   sld_outreg #(.W(NB*8 + 1), .REG_OUT(REG_OUT)) u_oreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_valid (in_valid),
      .d       ({reject, net_beat}),
      .q_valid (out_valid),
      .q       ({out_illegal, out_beat})
   );
endmodule

// File: rtl/sld_lane_slide_chk.sv
module sld_lane_slide_chk #(
   parameter int  NR_LANES = 4,
   parameter bit  REG_OUT  = 1'b1,
   localparam int NB       = NR_LANES * 8,
   localparam int AMT_W    = $clog2(NB) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [NB*8-1:0]  in_beat,
   input logic [1:0]       src_ew,
   input logic [1:0]       dst_ew,
   input logic [AMT_W-1:0] slide_amt,
   input logic             slide_dn,
   input logic             out_valid,
   input logic [NB*8-1:0]  out_beat,
   input logic             out_illegal
);
   if (REG_OUT) begin : g_seq
      p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> ($stable(out_beat) && $stable(out_illegal)));
      p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && slide_amt == '0 && src_ew == dst_ew)
         |=> (out_beat == $past(in_beat) && !out_illegal));
      p_mix_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && slide_amt != '0 && src_ew != dst_ew) |=> out_illegal);
      p_npow_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && $countones(slide_amt) > 1) |=> out_illegal);
      p_reshuffle_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && slide_amt == '0) |=> !out_illegal);
      p_illegal_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && out_illegal) |-> (out_beat == '0));
   end
endmodule

bind sld_lane_slide sld_lane_slide_chk #(.NR_LANES(NR_LANES), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sld_lane_slide_bench.sv
module sld_lane_slide_bench;
   localparam int CLK_PERIOD = 10;
   localparam int L     = 4;
   localparam int NB    = L * 8;
   localparam int AMT_W = $clog2(NB) + 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [NB*8-1:0]  in_beat = '0;
   logic [1:0]       src_ew = '0;
   logic [1:0]       dst_ew = '0;
   logic [AMT_W-1:0] slide_amt = '0;
   logic             slide_dn = 1'b0;
   logic             out_valid;
   logic [NB*8-1:0]  out_beat;
   logic             out_illegal;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sld_lane_slide #(.NR_LANES(L), .REG_OUT(1'b1)) u_sld_lane_slide (.*);

   function automatic int loc(int e, int b, int w);
      return (e % L) * 8 + (e / L) * w + b;
   endfunction

   function automatic logic [NB*8-1:0] ref_op(logic [NB*8-1:0] beat, int sw, int dw,
                                              int amt, bit dn, output bit ill);
      logic [NB*8-1:0] r;
      logic [7:0] q[$];
      int ws;
      int wd;
      r  = '0;
      ws = 1 << sw;
      wd = 1 << dw;
      ill = (amt != 0) && ((sw != dw) || ((amt & (amt - 1)) != 0));
      if (ill) return r;
      if (amt == 0) begin
         for (int e = 0; e < NB / ws; e++)
            for (int b = 0; b < ws; b++) q.push_back(beat[loc(e, b, ws)*8 +: 8]);
         for (int e = 0; e < NB / wd; e++)
            for (int b = 0; b < wd; b++) r[loc(e, b, wd)*8 +: 8] = q.pop_front();
      end else begin
         for (int e = 0; e < NB / ws; e++) begin
            int s;
            s = dn ? e + amt : e - amt;
            if (s >= 0 && s < NB / ws)
               for (int b = 0; b < ws; b++) r[loc(e, b, ws)*8 +: 8] = beat[loc(s, b, ws)*8 +: 8];
         end
      end
      return r;
   endfunction

   function automatic string tag_of(int sw, int dw, int amt, bit dn);
      if (amt != 0 && sw != dw) return "R6";
      if ((amt & (amt - 1)) != 0) return "R7";
      if (amt == 0) return (sw == dw) ? "R2" : "R5";
      if (amt >= (NB >> sw)) return "R8";
      return dn ? "R3 R1" : "R4 R1";
   endfunction

   // reference model state
   logic            exp_valid = 1'b0;
   logic            exp_ill   = 1'b0;
   logic [NB*8-1:0] exp_beat  = '0;
   string           exp_tag   = "R10";

   always @(posedge clk) begin
      bit ill;
      logic [NB*8-1:0] r;
      if (!rst_n) begin
         exp_valid <= 1'b0;
         exp_ill   <= 1'b0;
         exp_beat  <= '0;
         exp_tag   <= "R10";
      end else begin
         exp_valid <= in_valid;
         if (in_valid) begin
            r = ref_op(in_beat, int'(src_ew), int'(dst_ew), int'(slide_amt), slide_dn, ill);
            exp_beat <= r;
            exp_ill  <= ill;
            exp_tag  <= tag_of(int'(src_ew), int'(dst_ew), int'(slide_amt), slide_dn);
         end else begin
            exp_tag <= "R9";
         end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         total++;
         if (out_valid !== exp_valid || out_illegal !== exp_ill || out_beat !== exp_beat) begin
            bad++;
            $display("FAIL %s: valid=%0b ill=%0b beat=%h expected valid=%0b ill=%0b beat=%h",
                     exp_tag, out_valid, out_illegal, out_beat, exp_valid, exp_ill, exp_beat);
         end
      end
   end

   function automatic logic [NB*8-1:0] rnd_beat();
      logic [NB*8-1:0] v;
      for (int i = 0; i < NB / 4; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   task automatic drive(bit v, logic [NB*8-1:0] beat, int sw, int dw, int amt, bit dn);
      @(negedge clk);
      in_valid  = v;
      in_beat   = beat;
      src_ew    = sw[1:0];
      dst_ew    = dw[1:0];
      slide_amt = amt[AMT_W-1:0];
      slide_dn  = dn;
   endtask

   initial begin
      logic [NB*8-1:0] ramp;
      for (int i = 0; i < NB; i++) ramp[i*8 +: 8] = 8'(i + 1);
      repeat (3) @(negedge clk);   // R10 checked during reset
      rst_n = 1'b1;
      // R2 pass-through at every width
      for (int w = 0; w < 4; w++) drive(1, rnd_beat(), w, w, 0, 0);
      // R3 / R4 every width, every power-of-two amount
      for (int w = 0; w < 4; w++)
         for (int a = 1; a < NB; a = a * 2) begin
            drive(1, ramp, w, w, a, 1);
            drive(1, rnd_beat(), w, w, a, 0);
         end
      // R5 all reshuffle pairs
      for (int s = 0; s < 4; s++)
         for (int d = 0; d < 4; d++) if (s != d) drive(1, ramp, s, d, 0, 0);
      // R6 width change with slide, R7 non-power-of-two
      drive(1, ramp, 0, 1, 1, 1);
      drive(1, ramp, 3, 2, 4, 0);
      drive(1, ramp, 1, 1, 3, 1);
      drive(1, ramp, 2, 2, 6, 0);
      // R8 amount at or above element count
      drive(1, ramp, 3, 3, 4, 1);
      drive(1, ramp, 2, 2, 32, 0);
      // R9 idle cycles hold values
      drive(1, ramp, 0, 0, 2, 1);
      drive(0, rnd_beat(), 1, 1, 0, 0);
      drive(0, rnd_beat(), 0, 3, 5, 1);
      // random mix with idle gaps
      for (int n = 0; n < 400; n++) begin
         int amt;
         int pick;
         pick = $urandom_range(0, 9);
         amt  = (pick < 6) ? (1 << $urandom_range(0, 5)) : (pick < 8 ? 0 : $urandom_range(0, NB));
         if (amt >= (1 << AMT_W)) amt = 0;
         drive($urandom_range(0, 4) != 0, rnd_beat(),
               $urandom_range(0, 3), (pick == 9) ? $urandom_range(0, 3) : -1, amt, $urandom_range(0, 1));
      end
      drive(0, '0, 0, 0, 0, 0);
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule